// File: doc/BRIEF.md
# Pipelined Double-Precision Floating Adder-Subtractor

This block adds or subtracts two 64-bit binary floating-point numbers (1 sign bit, an 11-bit biased exponent, a 52-bit fraction). It is fully pipelined. A fresh operand pair, an operation select and a rounding-mode select may be presented with `in_valid` on any clock. The matching result comes out with `out_valid` a fixed number of cycles later.

The arithmetic path unpacks both operands, orders them by magnitude, and shifts the smaller one right. The bits shifted out are kept as guard, round and sticky bits. The path then adds or subtracts the significands, normalizes with a leading-zero count, rounds in the selected mode and packs the result. The result then travels down a delay chain, together with a valid bit, to the output.

The behaviour is simplified at the edges of the number range. An operand with a zero exponent field is taken as zero. Any operand with an all-ones exponent yields an infinity. A result too small to be normal becomes zero.

Top module: `fp64_addsub_pipe`

## Requirements
- R1: With `op_sub`=0 and `rnd_mode`=2'b00, `result` is A+B rounded to nearest with ties to an even fraction LSB, for normal operands and normal results.
- R2: With `op_sub`=1, `result` is A−B, computed as A plus B with bit 63 of B inverted, in every rounding mode.
- R3: `rnd_mode`=2'b01 rounds an inexact sum toward zero.
- R4: `rnd_mode`=2'b10 rounds an inexact sum toward +infinity.
- R5: `rnd_mode`=2'b11 rounds an inexact sum toward −infinity.
- R6: An operand whose exponent field (bits 62:52) is zero is used as a zero of the same sign, whatever its fraction bits are.
- R7: If either operand has exponent field 11'h7FF (infinity or NaN), the result is an infinity (exponent 7FF, fraction 0). Its sign is the sign of A when A is special. Otherwise its sign is the effective sign of B, meaning bit 63 of B XOR `op_sub`.
- R8: An exactly zero sum of two operands with different effective signs is +0, except under `rnd_mode`=2'b11, where it is −0. Two zeros of equal effective sign give a zero of that sign.
- R9: A nonzero exact sum whose magnitude is below 2^-1022 is returned as a zero carrying the sign of the exact sum.
- R10: On overflow the result is an infinity under `rnd_mode` 2'b00. It is also an infinity under 2'b10 for a positive sum and under 2'b11 for a negative sum. In all other overflow cases the result is the largest finite magnitude, 0x7FEFFFFFFFFFFFFF, with the sum's sign.
- R11: An operation presented with `in_valid`=1 in clock cycle c produces `out_valid`=1 and its `result` in cycle c+24. Back-to-back operations give one result per cycle. A cycle with `in_valid`=0 gives `out_valid`=0 24 cycles later.
- R12: A synchronous active-high `rst` clears `out_valid`, and any operation in flight at that time never appears at the output.
- R13: While `out_valid` is 1, `result` is never a NaN and never a nonzero value with exponent field zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present this cycle |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| op_sub | input | 1 | 0: A+B, 1: A−B |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward −inf |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 64 | Rounded sum or difference |

## Verification
Directed pairs set up exact ties, sums one half-ulp above a tie, carries out of the significand, overflow in each mode, total cancellation and underflowing cancellation. These cases separate the four rounding rules, the signed-zero rule and the overflow choice. Random pairs whose exponents differ by zero to two exercise deep left normalization. A spread of up to sixty exercises the sticky path, and the bench checks every combination of mode and operation against a reference built from host double arithmetic with an exact error term. Fully random bit patterns add flushed subnormals, infinities and NaNs. Streams are sent back to back and with gaps, and a reset is issued mid-stream, which together show whether each result arrives in its own cycle and whether flushed operations disappear.

// File: rtl/fp64_addsub_pipe.sv
module fp64_addsub_pipe #(
  parameter int LATENCY = 24
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic        op_sub,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [63:0] result
);
  localparam int EW = 11;
  localparam int FW = 52;
  localparam int MW = FW + 1;
  localparam int XW = MW + 3;
  localparam logic [EW-1:0] EMAX = '1;

  logic [EW-1:0] ea, eb, ex, ey, dexp;
  logic          sa, sb, sx, sy, a_big, spc_a, spc_b, eff_sub;
  logic [62:0]   mag_a, mag_b;
  logic [MW-1:0] mx, my;
  logic [5:0]    sh;
  logic [MW+63:0] ywide;
  logic [XW-1:0] xal, yal, norm;
  logic [XW:0]   sum;
  logic [6:0]    lz;
  logic signed [EW+1:0] en, ef;
  logic [MW:0]   rnd;
  logic          inexact, up, ovf, to_inf;
  logic [63:0]   comb_res;

  function automatic logic [6:0] lzc(input logic [XW-1:0] v);
    lzc = 7'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) lzc = 7'(XW - 1 - i);
  endfunction

  assign ea    = opa[62:52];
  assign eb    = opb[62:52];
  assign sa    = opa[63];
  assign sb    = opb[63] ^ op_sub;
  assign spc_a = (ea == EMAX);
  assign spc_b = (eb == EMAX);
  assign mag_a = (ea == '0) ? '0 : opa[62:0];
  assign mag_b = (eb == '0) ? '0 : opb[62:0];
  assign a_big = (mag_a >= mag_b);

  assign ex = a_big ? ea : eb;
  assign ey = a_big ? eb : ea;
  assign sx = a_big ? sa : sb;
  assign sy = a_big ? sb : sa;
  assign mx = {|ex, a_big ? mag_a[51:0] : mag_b[51:0]};
  assign my = {|ey, a_big ? mag_b[51:0] : mag_a[51:0]};

  assign dexp    = ex - ey;
  assign sh      = (dexp > 11'd63) ? 6'd63 : dexp[5:0];
  assign ywide   = {my, 64'b0} >> sh;
  assign xal     = {mx, 3'b000};
  assign yal     = {ywide[MW+63:62], |ywide[61:0]};
  assign eff_sub = sx ^ sy;
  assign sum     = eff_sub ? ({1'b0, xal} - {1'b0, yal}) : ({1'b0, xal} + {1'b0, yal});
  assign lz      = lzc(sum[XW-1:0]);

  always_comb begin
    if (sum[XW]) begin
      norm = {sum[XW:2], sum[1] | sum[0]};
      en   = $signed({2'b00, ex}) + 13'sd1;
    end else begin
      norm = sum[XW-1:0] << lz;
      en   = $signed({2'b00, ex}) - $signed({6'b0, lz});
    end
  end

  assign inexact = |norm[2:0];
  always_comb begin
    case (rnd_mode)
      2'b00:   up = norm[2] & (norm[1] | norm[0] | norm[3]);
      2'b10:   up = inexact & ~sx;
      2'b11:   up = inexact & sx;
      default: up = 1'b0;
    endcase
  end

  assign rnd    = {1'b0, norm[XW-1:3]} + {{MW{1'b0}}, up};
  assign ef     = en + $signed({12'b0, rnd[MW]});
  assign ovf    = (ef >= 13'sd2047);
  assign to_inf = (rnd_mode == 2'b00) || (rnd_mode == 2'b10 && !sx) || (rnd_mode == 2'b11 && sx);

  always_comb begin
    if (spc_a || spc_b)
      comb_res = {spc_a ? sa : sb, EMAX, 52'b0};
    else if (sum == '0)
      comb_res = {eff_sub ? (rnd_mode == 2'b11) : sx, 63'b0};
    else if (en <= 13'sd0)
      comb_res = {sx, 63'b0};
    else if (ovf)
      comb_res = to_inf ? {sx, EMAX, 52'b0} : {sx, 11'h7FE, {FW{1'b1}}};
    else
      comb_res = {sx, ef[EW-1:0], rnd[FW-1:0]};
  end

  logic [LATENCY-1:0] vpipe;
  logic [63:0]        dpipe [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else begin
      vpipe[0] <= in_valid;
      for (int i = 1; i < LATENCY; i++) vpipe[i] <= vpipe[i-1];
    end
  end

  always_ff @(posedge clk) begin
    dpipe[0] <= comb_res;
    for (int i = 1; i < LATENCY; i++) dpipe[i] <= dpipe[i-1];
  end

  assign out_valid = vpipe[LATENCY-1];
  assign result    = dpipe[LATENCY-1];
endmodule

// File: rtl/fp64_addsub_chk.sv
module fp64_addsub_chk #(
  parameter int LAT = 24
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        out_valid,
  input logic [63:0] result
);
  logic [LAT-1:0] v_sh, s_sh;
  logic           s_in;

  assign s_in = in_valid && (opa[62:52] == 11'h7FF || opb[62:52] == 11'h7FF);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_sh <= '0;
      s_sh <= '0;
    end else begin
      v_sh[0] <= in_valid;
      s_sh[0] <= s_in;
      for (int i = 1; i < LAT; i++) begin
        v_sh[i] <= v_sh[i-1];
        s_sh[i] <= s_sh[i-1];
      end
    end
  end

  // R11
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LAT-1]);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R7
  special_inf_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_sh[LAT-1]) |-> (result[62:52] == 11'h7FF && result[51:0] == '0));

  // R13
  no_nan_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(result[62:52] == 11'h7FF && result[51:0] != '0));

  // R9
  no_subnormal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (result[62:52] != '0 || result[51:0] == '0));
endmodule

bind fp64_addsub_pipe fp64_addsub_chk #(.LAT(LATENCY)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
  .out_valid(out_valid), .result(result)
);

// File: tb/fp64_addsub_pipe_tb_top.sv
`timescale 1ns/1ps
module fp64_addsub_pipe_tb_top;
  localparam int LAT = 24;
  localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        op_sub = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        out_valid;
  logic [63:0] result;

  int n_chk = 0, n_bad = 0;
  logic        q_v[$];
  logic [63:0] q_r[$];
  string       q_t[$];

  always #4 clk = ~clk;

  fp64_addsub_pipe #(.LATENCY(LAT)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opa(opa), .opb(opb),
    .op_sub(op_sub), .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                            input logic s, input logic [1:0] m);
    logic [63:0] fa, fb, r;
    real x, y, z, bb, err;
    fa = (a[62:52] == 0) ? {a[63], 63'b0} : a;
    fb = (b[62:52] == 0) ? {b[63], 63'b0} : b;
    fb[63] = fb[63] ^ s;
    if (a[62:52] == 11'h7FF) return {a[63], 11'h7FF, 52'b0};
    if (b[62:52] == 11'h7FF) return {fb[63], 11'h7FF, 52'b0};
    x = $bitstoreal(fa);
    y = $bitstoreal(fb);
    z = x + y;
    if (z == 0.0) return {(fa[63] == fb[63]) ? fa[63] : (m == 2'b11), 63'b0};
    r = $realtobits(z);
    if (r[62:52] == 11'h7FF) begin
      case (m)
        2'b01: r = {r[63], MAXF[62:0]};
        2'b10: r = r[63] ? {1'b1, MAXF[62:0]} : r;
        2'b11: r = r[63] ? r : MAXF;
        default: ;
      endcase
      return r;
    end
    bb  = z - x;
    err = (x - (z - bb)) + (y - bb);
    if (err != 0.0) begin
      case (m)
        2'b01: if ((err < 0.0) != r[63]) r = r - 1;
        2'b10: if (err > 0.0) r = r[63] ? r - 1 : r + 1;
        2'b11: if (err < 0.0) r = r[63] ? r + 1 : r - 1;
        default: ;
      endcase
    end
    if (r[62:52] == 0) r = {r[63], 63'b0};
    return r;
  endfunction

  function automatic string mode_tag(input logic s, input logic [1:0] m);
    case (m)
      2'b01:   return "R3";
      2'b10:   return "R4";
      2'b11:   return "R5";
      default: return s ? "R2" : "R1";
    endcase
  endfunction

  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic s, input logic [1:0] m, input string tag);
    logic ev;
    logic [63:0] er;
    string et;
    @(negedge clk);
    if (q_v.size() >= LAT) begin
      ev = q_v.pop_front();
      er = q_r.pop_front();
      et = q_t.pop_front();
      n_chk++;
      if (out_valid !== ev) begin
        n_bad++;
        $display("FAIL R11 (%s) out_valid=%0b expected=%0b", et, out_valid, ev);
      end else if (ev && result !== er) begin
        n_bad++;
        $display("FAIL %s result=%h expected=%h", et, result, er);
      end
    end
    in_valid = v; opa = a; opb = b; op_sub = s; rnd_mode = m;
    q_v.push_back(v);
    q_r.push_back(v ? ref_model(a, b, s, m) : 64'b0);
    q_t.push_back(v ? tag : "R11");
  endtask

  task automatic op4(input logic [63:0] a, input logic [63:0] b, input logic s, input string tag);
    for (int m = 0; m < 4; m++) step(1'b1, a, b, s, 2'(m), (tag == "") ? mode_tag(s, 2'(m)) : tag);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b1; opa = {$urandom, $urandom}; opb = {$urandom, $urandom};
    end
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R12 out_valid=%0b expected=0", out_valid);
    end
    rst = 1'b0; in_valid = 1'b0;
    q_v.delete(); q_r.delete(); q_t.delete();
    repeat (LAT) begin
      q_v.push_back(1'b0); q_r.push_back(64'b0); q_t.push_back("R12");
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [10:0] e1, d;
    do_reset(3);
    // R1 R3 R4 R5: ties, just above tie, plain sums, carry out
    op4(ONE, ONE, 1'b0, "");
    op4(ONE, 64'h3CA0_0000_0000_0000, 1'b0, "");
    op4(ONE, 64'h3CB8_0000_0000_0000, 1'b0, "");
    op4(64'h3FF0_0000_0000_0001, 64'h3CA0_0000_0000_0000, 1'b0, "");
    op4(64'hBFF0_0000_0000_0000, 64'hBCA8_0000_0000_0000, 1'b0, "");
    op4(64'h3FFF_FFFF_FFFF_FFFF, 64'h3CB0_0000_0000_0000, 1'b0, "");
    // R2 subtraction with borrow into the guard bits
    op4(ONE, 64'h3C90_0000_0000_0000, 1'b1, "R2");
    op4(64'h4000_0000_0000_0000, 64'h3FFF_FFFF_FFFF_FFFF, 1'b1, "R2");
    // R6 flushed operands
    op4(64'h000F_FFFF_FFFF_FFFF, ONE, 1'b0, "R6");
    op4(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003, 1'b1, "R6");
    // R7 infinities and NaNs
    op4(64'h7FF0_0000_0000_0000, ONE, 1'b0, "R7");
    op4(ONE, 64'h7FF0_0000_0000_0000, 1'b1, "R7");
    op4(64'hFFF8_0000_0000_0001, 64'h7FF0_0000_0000_0000, 1'b0, "R7");
    op4(64'h3FF8_0000_0000_0000, 64'hFFF4_0000_0000_0000, 1'b0, "R7");
    // R8 exact zeros
    op4(64'h3FF8_0000_0000_0000, 64'h3FF8_0000_0000_0000, 1'b1, "R8");
    op4(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R8");
    op4(64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, "R8");
    // R9 underflowing cancellation
    op4(64'h0018_0000_0000_0000, 64'h0010_0000_0000_0000, 1'b1, "R9");
    op4(64'h8018_0000_0000_0001, 64'h8010_0000_0000_0000, 1'b1, "R9");
    // R10 overflow
    op4(MAXF, MAXF, 1'b0, "R10");
    op4({1'b1, MAXF[62:0]}, MAXF, 1'b1, "R10");
    op4(MAXF, 64'h7C90_0000_0000_0000, 1'b0, "R10");
    op4({1'b1, MAXF[62:0]}, 64'hFC90_0000_0000_0000, 1'b0, "R10");
    // R11 gaps in the stream
    for (int i = 0; i < 30; i++)
      step(i % 3 != 0, {$urandom, $urandom}, {$urandom, $urandom}, 1'(i), 2'(i), "R11");
    // R12 reset with operations in flight
    do_reset(2);
    // near exponents: cancellation and sticky
    for (int i = 0; i < 1500; i++) begin
      e1 = 11'($urandom_range(2040, 70));
      d  = ($urandom_range(3, 0) == 0) ? 11'($urandom_range(60, 0)) : 11'($urandom_range(2, 0));
      step(1'b1, {1'($urandom), e1, $urandom, 20'($urandom)},
                 {1'($urandom), e1 - d, $urandom, 20'($urandom)},
           1'($urandom), 2'($urandom), "");
      q_t[q_t.size()-1] = mode_tag(op_sub, rnd_mode);
    end
    // full random bit patterns
    for (int i = 0; i < 1500; i++) begin
      step(1'b1, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 2'($urandom), "");
      q_t[q_t.size()-1] = mode_tag(op_sub, rnd_mode);
    end
    repeat (LAT + 2) step(1'b0, 64'b0, 64'b0, 1'b0, 2'b00, "R11");
    report();
    $finish;
  end
endmodule